// File: doc/BRIEF.md
# Masked Lowest-First Interrupt Dispatcher

This block sits between a set of expansion devices and the bus-select logic of a processor subsystem. Two groups of devices raise interrupt requests, an external group and an internal group, each with one request line per slot and its own enable mask. When at least one device is both requesting and enabled, the block records the select value the bus carries at that moment. It drives a one-hot select for the winning slot and pulses a request to fetch that device's service vector, which sits at a fixed offset in the device's address window. A tag identifies the group and slot being served.

Service is chained. Each completion strobe from the handler makes the block look at every request again. If anything eligible remains, the next winner is selected at once, without going back through the saved value. Only when nothing eligible is left does the block write the saved select back and return to idle.

A request whose enable bit is clear is never served. Software waiting on such a device would spin forever. A watchdog counter raises a hang indicator when this condition persists.

Top module: `irq_dispatch`

## Requirements
- R1: While reset is asserted, and after it is released with no request present, `sel_out`, `sel_we`, `vec_req`, `busy`, `tag_grp`, `tag_idx` and `hang` are all zero.
- R2: A slot is dispatched only when its request bit and the bit with the same index in its own group's mask are both 1. A request with a clear mask bit leaves `busy` low and `sel_out` unchanged.
- R3: Among eligible slots, every external slot ranks above every internal slot, and a lower index ranks above a higher one within a group. Slots that do not win stay pending and are served later.
- R4: On the clock edge that dispatches slot n, `sel_out` becomes a one-hot value with bit n set (the same bit for either group). `sel_we` and `vec_req` are high for exactly that one cycle. `busy` goes high, `tag_grp` is 0 for external or 1 for internal, and `tag_idx` equals n.
- R5: On a dispatch from idle, the select value is saved from `cur_sel` as sampled on that edge. Changes on `cur_sel` while `busy` is high are ignored.
- R6: While `busy` is high and `svc_done` is low, `sel_out`, `tag_grp` and `tag_idx` hold their values, and `sel_we` and `vec_req` stay low.
- R7: On an edge with `svc_done` high while busy, if any slot is eligible, the highest-ranked one is dispatched as in R4 and `busy` stays high. This includes the slot just served, if it still requests.
- R8: On an edge with `svc_done` high while busy, if no slot is eligible, `sel_out` takes the saved value. `sel_we` pulses for one cycle with `vec_req` low, and `busy`, `tag_grp` and `tag_idx` return to zero.
- R9: `svc_done` has no effect while idle.
- R10: `hang` rises after HANG_LIM consecutive clock edges on which some slot requests with its mask bit clear. It falls on the first edge on which no such slot exists.
- R11: `vec_addr` equals the vector offset VEC_OFS (008h by default) while `vec_req` is high, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req | input | SLOTS | External group request lines, bit n for slot n |
| int_req | input | SLOTS | Internal group request lines, bit n for slot n |
| ext_mask | input | SLOTS | External group enable mask |
| int_mask | input | SLOTS | Internal group enable mask |
| cur_sel | input | SLOTS | Select value currently on the bus |
| svc_done | input | 1 | Handler completion strobe |
| sel_out | output | SLOTS | Select value driven by the block |
| sel_we | output | 1 | One-cycle strobe marking a new `sel_out` |
| vec_req | output | 1 | One-cycle vector fetch request |
| vec_addr | output | WIN_AW | Window offset of the service vector |
| busy | output | 1 | A service chain is in progress |
| tag_grp | output | 1 | Group being served: 0 external, 1 internal |
| tag_idx | output | log2(SLOTS) | Slot being served |
| hang | output | 1 | Unenabled request persisted too long |

## Verification
The bench builds the block with SLOTS = 8 and HANG_LIM = 5. With eight slots per group, the cross-group ranking, the mask-per-group matching and the one-hot select can be checked against byte-sized values worked out by hand. The short hang limit lets the bench reach both sides of the counter boundary (one edge before the limit and the edge at the limit) within a few cycles. It also lets the bench check that the indicator clears on the same edge that serves the newly enabled slot.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SERVE = 1'b1
  } irqd_state_e;
endpackage

// File: rtl/irqd_prio.sv
// Fixed-priority pick: bit 0 of the combined vector wins.
module irqd_prio #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          valid,
  output logic [IW-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] first;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign seen[g+1] = seen[g] | vec[g];
      assign first[g]  = vec[g] & ~seen[g];
    end
  endgenerate

  assign valid = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/irqd_hang.sv
// Counts consecutive edges with a request whose enable bit is clear.
module irqd_hang #(
  parameter int SLOTS    = 8,
  parameter int HANG_LIM = 1024,
  localparam int CW      = $clog2(HANG_LIM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] ext_req,
  input  logic [SLOTS-1:0] ext_mask,
  input  logic [SLOTS-1:0] int_req,
  input  logic [SLOTS-1:0] int_mask,
  output logic             hang
);
  logic          stray;
  logic          cnt_en;
  logic [CW-1:0] cnt_q, cnt_d;

  assign stray = |((ext_req & ~ext_mask) | (int_req & ~int_mask));

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!stray) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != CW'(HANG_LIM)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hang = (cnt_q == CW'(HANG_LIM));
endmodule

// File: rtl/irqd_seq.sv
// Service sequencer: save, select, chain, restore.
module irqd_seq
  import irqd_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int SW   = $clog2(SLOTS),
  localparam int IW   = SW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_valid,
  input  logic [IW-1:0]    pick_idx,
  input  logic [SLOTS-1:0] cur_sel,
  input  logic             svc_done,
  output logic [SLOTS-1:0] sel_out,
  output logic             sel_we,
  output logic             vec_req,
  output logic             busy,
  output logic             tag_grp,
  output logic [SW-1:0]    tag_idx
);
  irqd_state_e      state_q, state_d;
  logic [SLOTS-1:0] sel_q, sel_d, save_q;
  logic             save_en, sel_en, tag_en;
  logic             we_q, we_d, vec_q, vec_d;
  logic             grp_q, grp_d;
  logic [SW-1:0]    idx_q, idx_d;
  logic [SLOTS-1:0] pick_oh;

  assign pick_oh = {{(SLOTS-1){1'b0}}, 1'b1} << pick_idx[SW-1:0];

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    grp_d   = grp_q;
    idx_d   = idx_q;
    save_en = 1'b0;
    sel_en  = 1'b0;
    tag_en  = 1'b0;
    we_d    = 1'b0;
    vec_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pick_valid) begin
          save_en = 1'b1;
          sel_en  = 1'b1;
          tag_en  = 1'b1;
          sel_d   = pick_oh;
          grp_d   = pick_idx[SW];
          idx_d   = pick_idx[SW-1:0];
          we_d    = 1'b1;
          vec_d   = 1'b1;
          state_d = ST_SERVE;
        end
      end
      ST_SERVE: begin
        if (svc_done) begin
          sel_en = 1'b1;
          tag_en = 1'b1;
          we_d   = 1'b1;
          if (pick_valid) begin
            sel_d = pick_oh;
            grp_d = pick_idx[SW];
            idx_d = pick_idx[SW-1:0];
            vec_d = 1'b1;
          end else begin
            sel_d   = save_q;
            grp_d   = 1'b0;
            idx_d   = '0;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      vec_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      vec_q   <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       save_q <= '0;
    else if (save_en) save_q <= cur_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= 1'b0;
      idx_q <= '0;
    end else if (tag_en) begin
      grp_q <= grp_d;
      idx_q <= idx_d;
    end
  end

  assign sel_out = sel_q;
  assign sel_we  = we_q;
  assign vec_req = vec_q;
  assign busy    = (state_q == ST_SERVE);
  assign tag_grp = grp_q;
  assign tag_idx = idx_q;
endmodule

// File: rtl/irq_dispatch.sv
// Masked lowest-first interrupt dispatcher (top). SLOTS must be a power of two.
module irq_dispatch #(
  parameter int                SLOTS    = 8,
  parameter int                HANG_LIM = 1024,
  parameter int                WIN_AW   = 11,
  parameter logic [WIN_AW-1:0] VEC_OFS  = 11'h008,
  localparam int               SW       = $clog2(SLOTS),
  localparam int               NALL     = 2 * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOTS-1:0]  ext_req,
  input  logic [SLOTS-1:0]  int_req,
  input  logic [SLOTS-1:0]  ext_mask,
  input  logic [SLOTS-1:0]  int_mask,
  input  logic [SLOTS-1:0]  cur_sel,
  input  logic              svc_done,
  output logic [SLOTS-1:0]  sel_out,
  output logic              sel_we,
  output logic              vec_req,
  output logic [WIN_AW-1:0] vec_addr,
  output logic              busy,
  output logic              tag_grp,
  output logic [SW-1:0]     tag_idx,
  output logic              hang
);
  // External slots occupy the low half so they outrank internal ones.
  logic [NALL-1:0] eligible;
  logic            pick_valid;
  logic [SW:0]     pick_idx;

  assign eligible = {int_req & int_mask, ext_req & ext_mask};

  irqd_prio #(.N(NALL)) u_prio (
    .vec   (eligible),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  irqd_seq #(.SLOTS(SLOTS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .cur_sel    (cur_sel),
    .svc_done   (svc_done),
    .sel_out    (sel_out),
    .sel_we     (sel_we),
    .vec_req    (vec_req),
    .busy       (busy),
    .tag_grp    (tag_grp),
    .tag_idx    (tag_idx)
  );

  irqd_hang #(.SLOTS(SLOTS), .HANG_LIM(HANG_LIM)) u_hang (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_req  (ext_req),
    .ext_mask (ext_mask),
    .int_req  (int_req),
    .int_mask (int_mask),
    .hang     (hang)
  );

  assign vec_addr = vec_req ? VEC_OFS : '0;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int SLOTS = 8,
  localparam int SW   = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SLOTS-1:0] ext_req,
  input logic [SLOTS-1:0] int_req,
  input logic [SLOTS-1:0] ext_mask,
  input logic [SLOTS-1:0] int_mask,
  input logic             svc_done,
  input logic [SLOTS-1:0] sel_out,
  input logic             sel_we,
  input logic             vec_req,
  input logic             busy,
  input logic             tag_grp,
  input logic [SW-1:0]    tag_idx,
  input logic             hang
);
  logic [SLOTS-1:0] ext_ok, int_ok;
  logic             stray;

  assign ext_ok = ext_req & ext_mask;
  assign int_ok = int_req & int_mask;
  assign stray  = |((ext_req & ~ext_mask) | (int_req & ~int_mask));

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(sel_out) == 1));

  p_vec_with_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (sel_we && busy));

  p_elig_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !tag_grp) |-> (($past(ext_ok) & sel_out) != '0));

  p_elig_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && tag_grp) |-> (($past(int_ok) & sel_out) != '0));

  p_lowest_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !tag_grp) |-> (($past(ext_ok) & (sel_out - 1'b1)) == '0));

  p_ext_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && tag_grp) |-> ($past(ext_ok) == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(svc_done)) |-> ($stable(sel_out) && !sel_we));

  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sel_we && !vec_req));

  p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy && svc_done && (ext_ok == '0) && (int_ok == '0)) |-> !sel_we);

  p_hang_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hang |-> $past(stray));
endmodule

bind irq_dispatch irq_dispatch_chk #(.SLOTS(SLOTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ext_req  (ext_req),
  .int_req  (int_req),
  .ext_mask (ext_mask),
  .int_mask (int_mask),
  .svc_done (svc_done),
  .sel_out  (sel_out),
  .sel_we   (sel_we),
  .vec_req  (vec_req),
  .busy     (busy),
  .tag_grp  (tag_grp),
  .tag_idx  (tag_idx),
  .hang     (hang)
);

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;
  localparam int LIM = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ext_req, int_req, ext_mask, int_mask, cur_sel;
  logic        svc_done;
  logic [7:0]  sel_out;
  logic        sel_we, vec_req, busy, tag_grp, hang;
  logic [10:0] vec_addr;
  logic [2:0]  tag_idx;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  irq_dispatch #(.SLOTS(8), .HANG_LIM(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req),
    .ext_mask(ext_mask), .int_mask(int_mask), .cur_sel(cur_sel),
    .svc_done(svc_done), .sel_out(sel_out), .sel_we(sel_we),
    .vec_req(vec_req), .vec_addr(vec_addr), .busy(busy),
    .tag_grp(tag_grp), .tag_idx(tag_idx), .hang(hang)
  );

  typedef struct packed {
    logic [7:0] er, ir, em, im, cs;
    logic       dn;
    logic [7:0] xs;
    logic       xwe, xvec, xbusy, xgrp;
    logic [2:0] xidx;
  } row_t;

  // One row per clock; expectations are sampled one edge after the drive.
  localparam row_t TBL [11] = '{
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h20, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R1 idle
    '{8'h0C, 8'h01, 8'hFF, 8'hFF, 8'h20, 1'b0, 8'h04, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2}, // R3 R4 ext2 wins
    '{8'h0C, 8'h01, 8'hFF, 8'hFF, 8'h40, 1'b0, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2}, // R5 R6 hold
    '{8'h08, 8'h01, 8'hFF, 8'hFF, 8'h40, 1'b1, 8'h08, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3}, // R7 ext3
    '{8'h00, 8'h01, 8'hFF, 8'hFF, 8'h40, 1'b1, 8'h01, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0}, // R7 int0
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h40, 1'b1, 8'h20, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}, // R8 restore
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h40, 1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R9 idle done
    '{8'h01, 8'h80, 8'hFE, 8'h80, 8'h10, 1'b0, 8'h80, 1'b1, 1'b1, 1'b1, 1'b1, 3'd7}, // R2 masked ext0, int7
    '{8'h01, 8'h00, 8'hFE, 8'h80, 8'h10, 1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}, // R8 R2
    '{8'h01, 8'h00, 8'hFE, 8'h80, 8'h10, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R2 never served
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h10, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}  // idle
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] er, ir, em, im, cs, input logic dn);
    ext_req = er; int_req = ir; ext_mask = em; int_mask = im;
    cur_sel = cs; svc_done = dn;
  endtask

  task automatic report;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    report();
  end

  initial begin
    rst_n = 1'b0;
    drive(8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sel", 16'(sel_out), 16'h00);
    chk("R1 flags", 16'({sel_we, vec_req, busy, tag_grp, hang}), 16'h0);
    chk("R1 tag", 16'(tag_idx), 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      drive(TBL[i].er, TBL[i].ir, TBL[i].em, TBL[i].im, TBL[i].cs, TBL[i].dn);
      @(negedge clk);
      chk($sformatf("row%0d sel R4 R8", i), 16'(sel_out), 16'(TBL[i].xs));
      chk($sformatf("row%0d we/vec/busy R6 R7", i), 16'({sel_we, vec_req, busy}),
          16'({TBL[i].xwe, TBL[i].xvec, TBL[i].xbusy}));
      chk($sformatf("row%0d tag R3", i), 16'({tag_grp, tag_idx}),
          16'({TBL[i].xgrp, TBL[i].xidx}));
      chk($sformatf("row%0d hang R10", i), 16'(hang), 16'h0);
    end

    // R10: stray ext2 held with its enable clear; R2: it is not served
    drive(8'h04, 8'h00, 8'hFB, 8'hFF, 8'h33, 1'b0);
    for (int k = 1; k < LIM; k++) begin
      @(negedge clk);
      chk("R10 below limit", 16'(hang), 16'h0);
      chk("R2 stray not served", 16'({busy, sel_out}), 16'h010);
    end
    @(negedge clk);
    chk("R10 at limit", 16'(hang), 16'h1);
    ext_mask = 8'hFF;
    @(negedge clk);
    chk("R10 clears", 16'(hang), 16'h0);
    chk("R4 ext2 dispatched", 16'({busy, sel_out}), 16'h104);
    chk("R11 vector offset", 16'(vec_addr), 16'h008);
    drive(8'h00, 8'h00, 8'hFF, 8'hFF, 8'h77, 1'b1);
    @(negedge clk);
    chk("R8 restore saved", 16'({busy, sel_out}), 16'h033);

    // R7: the same slot still requesting at completion is served again
    drive(8'h02, 8'h00, 8'hFF, 8'hFF, 8'h55, 1'b0);
    @(negedge clk);
    chk("R4 ext1", 16'({sel_we, vec_req, sel_out}), 16'h302);
    svc_done = 1'b1;
    @(negedge clk);
    chk("R7 reserve", 16'({sel_we, vec_req, busy, sel_out}), 16'h702);
    svc_done = 1'b0;
    @(negedge clk);
    chk("R11 addr idle", 16'(vec_addr), 16'h000);
    chk("R6 hold", 16'({sel_we, busy, sel_out}), 16'h102);
    drive(8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b1);
    @(negedge clk);
    chk("R8 restore 55", 16'({busy, sel_out}), 16'h055);

    // R1: reset in the middle of a service chain
    drive(8'h01, 8'h00, 8'hFF, 8'hFF, 8'h99, 1'b0);
    @(negedge clk);
    chk("R4 ext0", 16'({busy, sel_out}), 16'h101);
    rst_n = 1'b0;
    #2;
    chk("R1 async reset", 16'({busy, sel_we, vec_req, hang, sel_out}), 16'h000);
    @(negedge clk);
    drive(8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 16'({busy, sel_out}), 16'h000);

    report();
  end
endmodule